// File: doc/BRIEF.md
# Nonblocking Cache Line-Fill Buffer

This block handles misses for a small direct-mapped cache whose lines are 16 bytes, held as four 32-bit longwords. It contains the tag, line-valid and data arrays together with a single line-fill buffer. A core read request that hits the array, or hits a longword already in the fill buffer, is answered in the cycle it is presented.

A read that misses both the array and the buffer starts one line-sized burst on the external read port. The burst begins at the requested longword and wraps around the line. Each arriving longword is stored in the buffer with its own valid bit. The requested longword goes straight to the core in the cycle its beat arrives. That frees the core port while the other three beats are still on their way, and later requests that hit the array or an arrived longword are served at once.

Once the fourth beat has been taken, the whole line and its tag are written into the array in the next cycle, and the buffer empties. Only one miss can be outstanding. An instruction side and a data side each instantiate their own copy.

Top module: `lfb_cache`

## Requirements
- R1: After reset every line is invalid, the fill buffer is empty and `burstReq` is low, so the first read of any address misses.
- R2: A read that misses while no fill is active raises `burstReq` for exactly one burst. `burstAddr` carries the line address with bits [3:2] equal to the requested longword and bits [1:0] zero, and both stay stable until `burstAck` is high.
- R3: Beats arrive one per `beatValid` cycle in wrapping order, starting at the requested longword. The requested longword is returned (`reqReady` high, `rspData` equal to `beatData`) in the same cycle its beat arrives.
- R4: A read of a longword of the filling line that has already arrived is answered in the cycle it is presented, back to back, while the rest of the line is still arriving.
- R5: A read of a longword of the filling line that has not yet arrived waits. It is answered in exactly the cycle that longword's beat arrives.
- R6: A read that misses both the array and the buffer while a fill is active is stalled, and no new burst is requested until the current line has been written into the array. The read is then handled as a new miss.
- R7: In the cycle after the last beat is taken, the line and tag are written into the array, the line is marked valid and all longword valid bits clear. Later reads of that line are answered in the cycle they are presented.
- R8: A read that hits a valid array line is answered in the cycle it is presented, even while a fill for another line is in progress.
- R9: The cache is direct-mapped, indexed by address bits [6:4] with default parameters. Filling a line replaces the line at the same index, so the old address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Core read request, held until `reqReady` |
| reqAddr | input | ADDR_W | Byte address of the requested longword |
| reqReady | output | 1 | Request is answered this cycle |
| rspData | output | DATA_W | Read data, valid when `reqValid` and `reqReady` |
| burstReq | output | 1 | Line burst request, held until accepted |
| burstAddr | output | ADDR_W | Line address with the starting longword in bits [3:2] |
| burstAck | input | 1 | Burst request accepted |
| beatValid | input | 1 | A returning longword is on `beatData` |
| beatData | input | DATA_W | Returning longword |

## Verification
The bench aims at the partly filled line. It reads a longword one beat ahead of the bus: a design that waits for the whole line, or returns the stale buffer slot, shows up as a wrong latency or wrong data. It then re-reads longwords that have already arrived, back to back, during the fill; a design that blocks until the burst ends gives a non-zero latency there. A second miss is issued in the middle of a fill, and a monitor watches for a burst request overlapping pending beats, which is what a design that lets two misses through would produce. A starting longword in the last slot checks the wrap-around, and an index conflict checks that the replaced line misses again.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_FILL,
    ST_COMMIT
  } fillState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic fillStart;   // latch missed address, empty the buffer
    logic takeBeat;    // store the beat on beatData
    logic commitLine;  // copy buffer into the array
  } fillStrobe_t;

endpackage

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missReq,
  input  logic             burstAck,
  input  logic             beatValid,
  output fillStrobe_t      strobes,
  output logic             burstReq,
  output logic [OFF_W-1:0] beatCnt
);

  fillState_e state, stateNext;
  logic       lastBeat;

  assign lastBeat = (beatCnt == OFF_W'(WORDS - 1));

  always_comb begin
    stateNext = state;
    strobes   = '0;
    burstReq  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (missReq) begin
          strobes.fillStart = 1'b1;
          stateNext         = ST_REQ;
        end
      end
      ST_REQ: begin
        burstReq = 1'b1;
        if (burstAck) stateNext = ST_FILL;
      end
      ST_FILL: begin
        if (beatValid) begin
          strobes.takeBeat = 1'b1;
          if (lastBeat) stateNext = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        strobes.commitLine = 1'b1;
        stateNext          = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobes.fillStart) beatCnt <= '0;
      else if (strobes.takeBeat) beatCnt <= beatCnt + 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    burstReq && !burstAck |=> burstReq);  // R2

  AST_COMMIT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeBeat && lastBeat |=> strobes.commitLine);  // R7

endmodule

// File: rtl/lfb_datapath.sv
module lfb_datapath
  import lfb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobe_t       strobes,
  input  logic [OFF_W-1:0]  beatCnt,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] beatData,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspData,
  output logic              missReq,
  output logic [ADDR_W-1:0] burstAddr
);

  // Request address fields
  logic [TAG_W-1:0] reqTag;
  logic [IDX_W-1:0] reqIdx;
  logic [OFF_W-1:0] reqOff;
  logic             unusedByteBits;

  assign reqTag         = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx         = reqAddr[BYTE_W+OFF_W +: IDX_W];
  assign reqOff         = reqAddr[BYTE_W +: OFF_W];
  assign unusedByteBits = ^reqAddr[BYTE_W-1:0];

  // Cache array
  logic [LINES-1:0]                  lineValid;
  logic [TAG_W-1:0]                  tagMem  [LINES];
  logic [WORDS-1:0][DATA_W-1:0]      dataMem [LINES];

  // Fill buffer
  logic [TAG_W-1:0]             fbTag;
  logic [IDX_W-1:0]             fbIdx;
  logic [OFF_W-1:0]             fbOff;
  logic [WORDS-1:0]             wordValid;
  logic [WORDS-1:0][DATA_W-1:0] fbData;
  logic [OFF_W-1:0]             beatOff;

  // Wrapping order: beat n lands at start word + n
  assign beatOff   = fbOff + beatCnt;
  assign burstAddr = {fbTag, fbIdx, fbOff, {BYTE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
      wordValid <= '0;
      fbTag     <= '0;
      fbIdx     <= '0;
      fbOff     <= '0;
    end else begin
      if (strobes.fillStart) begin
        fbTag     <= reqTag;
        fbIdx     <= reqIdx;
        fbOff     <= reqOff;
        wordValid <= '0;
      end
      if (strobes.takeBeat) wordValid[beatOff] <= 1'b1;
      if (strobes.commitLine) begin
        lineValid[fbIdx] <= 1'b1;
        wordValid        <= '0;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_fbWord
    logic [DATA_W-1:0] wordReg;
    always_ff @(posedge clk) begin
      if (strobes.takeBeat && beatOff == OFF_W'(w)) wordReg <= beatData;
    end
    assign fbData[w] = wordReg;
  end

  always_ff @(posedge clk) begin
    if (strobes.commitLine) begin
      tagMem[fbIdx]  <= fbTag;
      dataMem[fbIdx] <= fbData;
    end
  end

  // Lookup in array, buffer and the beat now arriving
  logic arrayHit, fbLine, bufHit, fwdHit;

  always_comb begin
    arrayHit = lineValid[reqIdx] && (tagMem[reqIdx] == reqTag);
    fbLine   = (fbTag == reqTag) && (fbIdx == reqIdx);
    bufHit   = fbLine && wordValid[reqOff];
    fwdHit   = fbLine && strobes.takeBeat && (beatOff == reqOff);
    if (fwdHit)      rspData = beatData;
    else if (bufHit) rspData = fbData[reqOff];
    else             rspData = dataMem[reqIdx][reqOff];
    reqReady = reqValid && (arrayHit || bufHit || fwdHit);
    missReq  = reqValid && !(arrayHit || bufHit || fwdHit);
  end

  AST_EMPTY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillStart |-> wordValid == '0);  // R6

  AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitLine |=> wordValid == '0);  // R7

  AST_ONE_MORE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeBeat |=> $countones(wordValid) == $countones($past(wordValid)) + 1);  // R4

endmodule

// File: rtl/lfb_cache.sv
module lfb_cache
  import lfb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspData,
  output logic              burstReq,
  output logic [ADDR_W-1:0] burstAddr,
  input  logic              burstAck,
  input  logic              beatValid,
  input  logic [DATA_W-1:0] beatData
);

  fillStrobe_t      strobes;
  logic             missReq;
  logic [OFF_W-1:0] beatCnt;

  lfb_ctrl #(.WORDS(WORDS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .missReq  (missReq),
    .burstAck (burstAck),
    .beatValid(beatValid),
    .strobes  (strobes),
    .burstReq (burstReq),
    .beatCnt  (beatCnt)
  );

  lfb_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES),
    .WORDS (WORDS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .beatCnt  (beatCnt),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .beatData (beatData),
    .reqReady (reqReady),
    .rspData  (rspData),
    .missReq  (missReq),
    .burstAddr(burstAddr)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    burstReq && !burstAck |=> $stable(burstAddr));  // R2

endmodule

// File: tb/lfb_cache_tb_top.sv
`timescale 1ns/1ps
module lfb_cache_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [15:0] reqAddr;
  logic        reqReady;
  logic [31:0] rspData;
  logic        burstReq;
  logic [15:0] burstAddr;
  logic        burstAck;
  logic        beatValid;
  logic [31:0] beatData;

  always #2.5 clk = ~clk;

  lfb_cache dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspData(rspData), .burstReq(burstReq),
    .burstAddr(burstAddr), .burstAck(burstAck), .beatValid(beatValid),
    .beatData(beatData)
  );

  int          checks = 0;
  int          errors = 0;
  int          beatGap = 0;
  int          burstCount = 0;
  int          overlapErr = 0;
  bit          beatsPending = 0;
  logic [15:0] lastBurstAddr = '0;

  function automatic logic [31:0] refWord(input logic [15:0] a);
    return {a[15:2], 2'b01, ~a[15:2], 2'b10};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Burst responder: wrapping order from the start longword in burstAddr
  initial begin
    burstAck = 1'b0; beatValid = 1'b0; beatData = '0;
    forever begin
      @(negedge clk);
      if (rstN && burstReq) begin
        logic [15:0] a;
        a = burstAddr;
        lastBurstAddr = a;
        burstCount++;
        @(posedge clk); #1;
        burstAck = 1'b1;
        beatsPending = 1'b1;
        @(posedge clk); #1;
        burstAck = 1'b0;
        for (int i = 0; i < 4; i++) begin
          if (i > 0) repeat (beatGap) begin @(posedge clk); #1; end
          beatValid = 1'b1;
          beatData  = refWord({a[15:4], 2'(a[3:2] + i), 2'b00});
          @(posedge clk); #1;
          beatValid = 1'b0;
        end
        beatsPending = 1'b0;
      end
    end
  end

  // R6 monitor: no new burst request while beats are still pending
  initial begin
    logic prevReq;
    prevReq = 1'b0;
    forever begin
      @(negedge clk);
      if (burstReq && !prevReq && beatsPending) overlapErr++;
      prevReq = burstReq;
    end
  end

  // Core read; lat = cycles waited (0 = answered in the presenting cycle)
  task automatic coreRead(input logic [15:0] a, output int lat, output logic [31:0] d, output bit bv);
    reqValid = 1'b1;
    reqAddr  = a;
    lat      = 0;
    @(negedge clk);
    while (!reqReady && lat < 1000) begin
      lat++;
      @(negedge clk);
    end
    d  = rspData;
    bv = beatValid;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (beatsPending) begin @(posedge clk); #1; end
    repeat (2) begin @(posedge clk); #1; end
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic        hit;
  } vecT;

  localparam vecT VECS [11] = '{
    '{16'h0108, 1'b0},  // first read after reset: miss
    '{16'h0100, 1'b1},
    '{16'h010C, 1'b1},
    '{16'h0104, 1'b1},
    '{16'h0234, 1'b0},
    '{16'h0230, 1'b1},
    '{16'h0884, 1'b0},  // same index as 0x0108, replaces it
    '{16'h0100, 1'b0},  // evicted line misses again
    '{16'h0238, 1'b1},
    '{16'h7FFC, 1'b0},  // start in last slot, wraps
    '{16'h7FF0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  initial begin
    int          lat;
    logic [31:0] d;
    bit          bv;
    int          bc;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(burstReq == 1'b0, "R1 burstReq after reset", 32'(burstReq), 0);
    chk(reqReady == 1'b0, "R1 reqReady after reset", 32'(reqReady), 0);
    @(posedge clk); #1;

    // Vector table: misses and array hits, buffer idle between reads
    for (int i = 0; i < 11; i++) begin
      coreRead(VECS[i].addr, lat, d, bv);
      chk(d == refWord(VECS[i].addr), "R3/R7 read data", d, refWord(VECS[i].addr));
      if (VECS[i].hit) begin
        chk(lat == 0, "R7/R8 array hit latency", 32'(lat), 0);
      end else begin
        chk(lat > 0, "R1/R9 expected miss latency", 32'(lat), 1);
        chk(bv == 1'b1, "R3 forwarded with its beat", 32'(bv), 1);
        chk(lastBurstAddr == {VECS[i].addr[15:2], 2'b00}, "R2 burst address",
            32'(lastBurstAddr), 32'({VECS[i].addr[15:2], 2'b00}));
      end
      waitIdle();
    end

    // Partial-line service during a slow burst
    beatGap = 3;
    coreRead(16'h1408, lat, d, bv);
    chk(d == refWord(16'h1408) && bv, "R3 critical longword", d, refWord(16'h1408));
    coreRead(16'h140C, lat, d, bv);
    chk(lat == beatGap, "R5 wait until beat arrives", 32'(lat), 32'(beatGap));
    chk(d == refWord(16'h140C) && bv, "R5 data on arrival", d, refWord(16'h140C));
    coreRead(16'h1408, lat, d, bv);
    chk(lat == 0 && d == refWord(16'h1408), "R4 buffer hit word2", d, refWord(16'h1408));
    coreRead(16'h140C, lat, d, bv);
    chk(lat == 0 && d == refWord(16'h140C), "R4 buffer hit word3", d, refWord(16'h140C));
    chk(beatsPending == 1'b1, "R8 fill still active", 32'(beatsPending), 1);
    coreRead(16'h0234, lat, d, bv);
    chk(lat == 0 && d == refWord(16'h0234), "R8 array hit during fill", d, refWord(16'h0234));
    bc = burstCount;
    coreRead(16'h2040, lat, d, bv);
    chk(lat > 0 && d == refWord(16'h2040), "R6 stalled miss data", d, refWord(16'h2040));
    chk(burstCount == bc + 1, "R6 one new burst", 32'(burstCount), 32'(bc + 1));
    chk(lastBurstAddr == 16'h2040, "R2 burst address second miss", 32'(lastBurstAddr), 32'h2040);
    coreRead(16'h1400, lat, d, bv);
    chk(lat == 0 && d == refWord(16'h1400), "R7 committed line hit", d, refWord(16'h1400));
    coreRead(16'h1404, lat, d, bv);
    chk(lat == 0 && d == refWord(16'h1404), "R7 committed line hit word1", d, refWord(16'h1404));
    waitIdle();
    chk(overlapErr == 0, "R6 no burst while beats pending", 32'(overlapErr), 0);

    // Reset clears the array
    beatGap = 0;
    rstN = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    @(negedge clk);
    chk(burstReq == 1'b0, "R1 burstReq in reset", 32'(burstReq), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    coreRead(16'h1400, lat, d, bv);
    chk(lat > 0 && d == refWord(16'h1400), "R1 miss after reset", 32'(lat), 1);
    waitIdle();

    finishRun();
  end

endmodule